// File: doc/BRIEF.md
# External Status Change Latch with Interrupt

This block watches a small group of asynchronous status lines (modem control inputs and a break indication) together with a transmit underrun/end-of-message flag that it keeps itself. When an enabled status bit changes, the block freezes a snapshot of the whole status word and raises an interrupt request. The snapshot stays visible, so a pulse too short for software to poll is still seen. The freeze holds until the CPU issues a reset-external-status command strobe, which re-opens the latch.

A change that arrives while an earlier one is still waiting is held in a one-deep queue. The queue keeps its own snapshot. When the pending change is reset, the queued change takes its place and the interrupt stays raised. Any further changes that arrive while the queue is occupied are merged into the one already queued.

The underrun/end-of-message bit is set when CRC transmission starts. A clear command removes it only while the transmitter is enabled. While the transmitter is disabled, the clear command leaves the latch set. Instead it produces a status interrupt whose snapshot shows the bit as zero. This happens only when no interrupt is pending, or when the command arrives in the same cycle as a reset-external-status command.

Top module: `ext_status_latch`

## Requirements
- R1: While no interrupt is pending, a change on `status_in` appears on the matching low bit of `status_word` at the second rising clock edge after the input is applied.
- R2: A change of a bit whose `int_mask` bit is 1 sets `irq_pending` one edge after the change reaches `status_word`. The enabled bits of `status_word` then hold that captured value, even if the inputs change again.
- R3: `irq_pending` stays at 1 until a `cmd_reset_ext` strobe. A strobe with no queued change and no new change in the same cycle clears it on that edge.
- R4: An enabled change that arrives while an interrupt is pending is queued. The next `cmd_reset_ext` keeps `irq_pending` at 1 and shows the snapshot taken when the queued change occurred.
- R5: While a change is already queued, further enabled changes are merged into it. The queued snapshot keeps its first value, and one extra `cmd_reset_ext` is enough to clear `irq_pending`.
- R6: A bit whose `int_mask` bit is 0 never raises or queues an interrupt. It follows its input on `status_word`, even while an interrupt is pending.
- R7: A `crc_start` strobe sets the underrun/EOM latch, which is the top bit of `status_word` (bit NUM_LINES). Lines 0 to NUM_LINES-1 occupy the bits below it. When enabled, the new value raises an interrupt like any other status change.
- R8: A `cmd_reset_eom` strobe while `tx_enable` is 1 clears the underrun/EOM latch. When enabled, that change raises an interrupt.
- R9: A `cmd_reset_eom` strobe while `tx_enable` is 0 leaves the underrun/EOM latch set.
- R10: With `tx_enable` at 0 and no interrupt pending, a `cmd_reset_eom` strobe (with the latch's mask bit set) raises `irq_pending`. The captured snapshot shows the underrun/EOM bit as 0.
- R11: With `tx_enable` at 0 and an interrupt pending, `cmd_reset_eom` alone has no effect. If it comes together with `cmd_reset_ext`, a fresh interrupt with the underrun/EOM bit shown as 0 is raised.
- R12: After reset, `status_word` is all zeros and `irq_pending` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| status_in | input | NUM_LINES | Raw asynchronous status lines |
| crc_start | input | 1 | One-cycle strobe: CRC transmission begins |
| tx_enable | input | 1 | Transmitter enabled level |
| int_mask | input | NUM_LINES+1 | Per-bit interrupt enable (top bit is underrun/EOM) |
| cmd_reset_ext | input | 1 | Decoded reset-external-status command strobe |
| cmd_reset_eom | input | 1 | Decoded reset-underrun/EOM command strobe |
| status_word | output | NUM_LINES+1 | Latched or transparent status, underrun/EOM on top |
| irq_pending | output | 1 | External status interrupt pending |

## Verification
The hardest situations to reach from the ports are the ones where two things must line up within one cycle. The first is the disabled-transmitter clear that coincides with a reset-external-status strobe while an interrupt is pending. The second is a run of changes that land while the one-deep queue is already full. The stimulus first builds a pending interrupt through a line change. It then drives both command strobes on the same clock edge. For the queue case, it applies several line patterns three cycles apart before any reset. The visible snapshot after each reset then shows which capture survived.

// File: rtl/esl_pkg.sv
// Package: shared types for the external status latch.
// Assumes: nothing beyond the standard language.
package esl_pkg;

    // Freeze state: open (transparent), held, held with one change queued
    typedef enum logic [1:0] {
        LS_OPEN   = 2'd0,
        LS_HELD   = 2'd1,
        LS_HELD_Q = 2'd2
    } latch_state_e;

endpackage

// File: rtl/esl_sync.sv
// Module: two-flop synchronizer for the raw status lines.
// Assumes: inputs are asynchronous level signals, each bit independent.
module esl_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Two register stages per line, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;

endmodule

// File: rtl/esl_eom_latch.sv
// Module: transmit underrun/end-of-message latch.
// Set by the CRC-start strobe; cleared by its command only while the
// transmitter is enabled. With the transmitter disabled the command instead
// requests a synthetic status event (bit reported as zero) when the freeze
// logic is open or is being reset in the same cycle.
// Assumes: strobes are single-cycle and synchronous to clk.
module esl_eom_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic crc_start,
    input  logic tx_enable,
    input  logic cmd_reset_eom,
    input  logic cmd_reset_ext,
    input  logic held,
    input  logic mask_bit,
    output logic eom_o,
    output logic virt_ev_o
);

    logic eom_q;

    // Latch update: set on CRC start (wins), clear only with transmitter on
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eom_q <= 1'b0;
        end else if (crc_start) begin
            eom_q <= 1'b1;
        end else if (cmd_reset_eom && tx_enable) begin
            eom_q <= 1'b0;
        end
    end

    // Synthetic event request for the disabled-transmitter case
    always_comb begin
        virt_ev_o = cmd_reset_eom && !tx_enable && mask_bit &&
                    (!held || cmd_reset_ext);
    end

    assign eom_o = eom_q;

    p_crc_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        crc_start |=> eom_q);

    p_enabled_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_reset_eom && tx_enable && !crc_start) |=> !eom_q);

    p_disabled_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_reset_eom && !tx_enable && eom_q) |=> eom_q);

endmodule

// File: rtl/esl_freeze.sv
// Module: change detection, snapshot freeze and one-deep change queue.
// Compares the current status vector with its value one cycle earlier. An
// enabled change (or a synthetic event) captures a snapshot and holds it
// until a reset command; one further event is queued, later ones merge.
// Assumes: cur_i is synchronous to clk; virt_val_i is the value to capture
// for a synthetic event.
module esl_freeze
    import esl_pkg::*;
#(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] cur_i,
    input  logic [WIDTH-1:0] mask_i,
    input  logic             cmd_reset_ext,
    input  logic             virt_ev_i,
    input  logic [WIDTH-1:0] virt_val_i,
    output logic [WIDTH-1:0] status_o,
    output logic             held_o
);

    latch_state_e     state_q, state_d;
    logic [WIDTH-1:0] cur_d_q;
    logic [WIDTH-1:0] snap_q, snap_d;
    logic [WIDTH-1:0] qsnap_q, qsnap_d;
    logic [WIDTH-1:0] chg;
    logic             ev_now;
    logic [WIDTH-1:0] ev_val;

    // Previous-cycle copy of the status vector for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) cur_d_q <= '0;
        else        cur_d_q <= cur_i;
    end

    // Enabled changes and the value an event would capture
    always_comb begin
        chg    = (cur_i ^ cur_d_q) & mask_i;
        ev_now = (|chg) || virt_ev_i;
        ev_val = virt_ev_i ? virt_val_i : cur_i;
    end

    // Next-state logic for freeze, queue and merge
    always_comb begin
        state_d = state_q;
        snap_d  = snap_q;
        qsnap_d = qsnap_q;
        unique case (state_q)
            LS_OPEN: begin
                if (ev_now) begin
                    state_d = LS_HELD;
                    snap_d  = ev_val;
                end
            end
            LS_HELD: begin
                if (cmd_reset_ext) begin
                    if (ev_now) begin
                        snap_d = ev_val;
                    end else begin
                        state_d = LS_OPEN;
                    end
                end else if (ev_now) begin
                    state_d = LS_HELD_Q;
                    qsnap_d = ev_val;
                end
            end
            LS_HELD_Q: begin
                if (cmd_reset_ext) begin
                    snap_d = qsnap_q;
                    if (ev_now) begin
                        qsnap_d = ev_val;
                    end else begin
                        state_d = LS_HELD;
                    end
                end
            end
            default: state_d = LS_OPEN;
        endcase
    end

    // State and snapshot registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LS_OPEN;
            snap_q  <= '0;
            qsnap_q <= '0;
        end else begin
            state_q <= state_d;
            snap_q  <= snap_d;
            qsnap_q <= qsnap_d;
        end
    end

    // Output: enabled bits frozen while held, others transparent
    always_comb begin
        held_o = (state_q != LS_OPEN);
        if (held_o) status_o = (snap_q & mask_i) | (cur_i & ~mask_i);
        else        status_o = cur_i;
    end

    p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && !cmd_reset_ext) |=> $stable(snap_q));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && !cmd_reset_ext) |=> held_o);

    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_HELD && cmd_reset_ext && !ev_now) |=> !held_o);

    p_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_HELD_Q && cmd_reset_ext) |=> (held_o && snap_q == $past(qsnap_q)));

    p_merge_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_HELD_Q && !cmd_reset_ext) |=> $stable(qsnap_q));

    p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!held_o && !ev_now) |=> !held_o);

endmodule

// File: rtl/ext_status_latch.sv
// Module: external status latch with interrupt (top).
// Synchronizes the raw lines, appends the underrun/EOM latch as the top
// status bit and feeds the freeze logic that drives the interrupt flag.
// Assumes: command and CRC strobes are one cycle wide and already decoded.
module ext_status_latch #(
    parameter int NUM_LINES = 4,
    localparam int WIDTH    = NUM_LINES + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] status_in,
    input  logic                 crc_start,
    input  logic                 tx_enable,
    input  logic [WIDTH-1:0]     int_mask,
    input  logic                 cmd_reset_ext,
    input  logic                 cmd_reset_eom,
    output logic [WIDTH-1:0]     status_word,
    output logic                 irq_pending
);

    logic [NUM_LINES-1:0] lines_sync;
    logic                 eom_bit;
    logic                 virt_ev;
    logic                 held;
    logic [WIDTH-1:0]     cur_vec;
    logic [WIDTH-1:0]     virt_vec;

    esl_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (status_in),
        .sync_o  (lines_sync)
    );

    esl_eom_latch u_eom (
        .clk           (clk),
        .rst_n         (rst_n),
        .crc_start     (crc_start),
        .tx_enable     (tx_enable),
        .cmd_reset_eom (cmd_reset_eom),
        .cmd_reset_ext (cmd_reset_ext),
        .held          (held),
        .mask_bit      (int_mask[WIDTH-1]),
        .eom_o         (eom_bit),
        .virt_ev_o     (virt_ev)
    );

    // Assemble live vector and the synthetic-event capture value
    always_comb begin
        cur_vec  = {eom_bit, lines_sync};
        virt_vec = {1'b0, lines_sync};
    end

    esl_freeze #(.WIDTH(WIDTH)) u_freeze (
        .clk           (clk),
        .rst_n         (rst_n),
        .cur_i         (cur_vec),
        .mask_i        (int_mask),
        .cmd_reset_ext (cmd_reset_ext),
        .virt_ev_i     (virt_ev),
        .virt_val_i    (virt_vec),
        .status_o      (status_word),
        .held_o        (held)
    );

    assign irq_pending = held;

    p_virt_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_reset_eom && !tx_enable && int_mask[WIDTH-1] && !crc_start && !irq_pending)
        |=> (irq_pending && !status_word[WIDTH-1]));

    p_virt_with_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_reset_eom && cmd_reset_ext && !tx_enable && int_mask[WIDTH-1] && !crc_start)
        |=> irq_pending);

endmodule

// File: tb/test_ext_status_latch.sv
module test_ext_status_latch;

    localparam int NL = 4;
    localparam int W  = NL + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] status_in = '0;
    logic          crc_start = 1'b0;
    logic          tx_enable = 1'b0;
    logic [W-1:0]  int_mask = '1;
    logic          cmd_reset_ext = 1'b0;
    logic          cmd_reset_eom = 1'b0;
    logic [W-1:0]  status_word;
    logic          irq_pending;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ext_status_latch #(.NUM_LINES(NL)) i_ext_status_latch (
        .clk           (clk),
        .rst_n         (rst_n),
        .status_in     (status_in),
        .crc_start     (crc_start),
        .tx_enable     (tx_enable),
        .int_mask      (int_mask),
        .cmd_reset_ext (cmd_reset_ext),
        .cmd_reset_eom (cmd_reset_eom),
        .status_word   (status_word),
        .irq_pending   (irq_pending)
    );

    // Vector: {lines[3:0], mask[4:0], exp_pending, exp_word[4:0]}
    localparam logic [14:0] VEC [6] = '{
        {4'b0001, 5'b11111, 1'b1, 5'b00001},
        {4'b0011, 5'b11101, 1'b0, 5'b00011},
        {4'b0111, 5'b11111, 1'b1, 5'b00111},
        {4'b0101, 5'b00000, 1'b0, 5'b00101},
        {4'b1101, 5'b01000, 1'b1, 5'b01101},
        {4'b0000, 5'b11111, 1'b1, 5'b00000}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic pulse_ext();
        cmd_reset_ext = 1'b1;
        tick(1);
        cmd_reset_ext = 1'b0;
    endtask

    task automatic pulse_eom();
        cmd_reset_eom = 1'b1;
        tick(1);
        cmd_reset_eom = 1'b0;
    endtask

    task automatic pulse_crc();
        crc_start = 1'b1;
        tick(1);
        crc_start = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        tick(3);
        // R12: reset state
        chk("R12 word", 8'(status_word), 8'd0);
        chk("R12 pending", 8'(irq_pending), 8'd0);
        rst_n = 1'b1;
        tick(2);
        chk("R12 word after release", 8'(status_word), 8'd0);

        // Table walk: R2 R6 basic change/mask patterns
        for (int i = 0; i < 6; i++) begin
            status_in = VEC[i][14:11];
            int_mask  = VEC[i][10:6];
            tick(3);
            chk($sformatf("R2/R6 vec%0d pending", i), 8'(irq_pending), 8'(VEC[i][5]));
            chk($sformatf("R2/R6 vec%0d word", i), 8'(status_word), 8'(VEC[i][4:0]));
            pulse_ext();
            chk($sformatf("R3 vec%0d cleared", i), 8'(irq_pending), 8'd0);
        end

        // R1: transparent latency of two edges
        int_mask = '0;
        status_in = 4'b0001;
        tick(1);
        chk("R1 one edge", 8'(status_word), 8'b00000);
        tick(1);
        chk("R1 two edges", 8'(status_word), 8'b00001);
        chk("R6 masked no irq", 8'(irq_pending), 8'd0);
        status_in = 4'b0000;
        tick(3);
        int_mask = '1;

        // R2 freeze, R4 queue, R3 release
        status_in = 4'b0001;
        tick(3);
        chk("R2 pending", 8'(irq_pending), 8'd1);
        status_in = 4'b0000;
        tick(3);
        chk("R2 frozen word", 8'(status_word), 8'b00001);
        pulse_ext();
        chk("R4 still pending", 8'(irq_pending), 8'd1);
        chk("R4 queued snapshot", 8'(status_word), 8'b00000);
        pulse_ext();
        chk("R3 released", 8'(irq_pending), 8'd0);

        // R5 merge
        status_in = 4'b0001; tick(3);
        status_in = 4'b0011; tick(3);
        status_in = 4'b0111; tick(3);
        pulse_ext();
        chk("R5 first queued kept", 8'(status_word), 8'b00011);
        chk("R5 pending after drain", 8'(irq_pending), 8'd1);
        pulse_ext();
        chk("R5 one reset clears merge", 8'(irq_pending), 8'd0);
        chk("R5 transparent", 8'(status_word), 8'b00111);
        status_in = 4'b0000; tick(3);
        pulse_ext();

        // R6 masked bit follows while held, never queues
        int_mask = 5'b11101;
        status_in = 4'b0001; tick(3);
        status_in = 4'b0011; tick(3);
        chk("R6 masked follows held", 8'(status_word), 8'b00011);
        pulse_ext();
        chk("R6 masked not queued", 8'(irq_pending), 8'd0);
        status_in = 4'b0000; tick(3);
        pulse_ext();
        int_mask = '1;

        // R7 CRC start sets latch
        pulse_crc();
        tick(1);
        chk("R7 pending", 8'(irq_pending), 8'd1);
        chk("R7 word", 8'(status_word), 8'b10000);
        pulse_ext();
        chk("R7 latch stays", 8'(status_word), 8'b10000);

        // R8 clear with transmitter enabled
        tx_enable = 1'b1;
        pulse_eom();
        tick(1);
        chk("R8 change irq", 8'(irq_pending), 8'd1);
        chk("R8 cleared word", 8'(status_word), 8'b00000);
        pulse_ext();

        // R9/R10 disabled transmitter, nothing pending
        pulse_crc();
        tick(1);
        pulse_ext();
        chk("R9 setup", 8'(status_word), 8'b10000);
        tx_enable = 1'b0;
        pulse_eom();
        chk("R10 pending", 8'(irq_pending), 8'd1);
        chk("R10 eom shown zero", 8'(status_word), 8'b00000);
        pulse_ext();
        chk("R9 latch kept", 8'(status_word), 8'b10000);
        chk("R9 released", 8'(irq_pending), 8'd0);

        // R11 disabled transmitter with interrupt pending
        status_in = 4'b0001; tick(3);
        pulse_eom();
        chk("R11 alone no effect word", 8'(status_word), 8'b10001);
        pulse_ext();
        chk("R11 alone not queued", 8'(irq_pending), 8'd0);
        status_in = 4'b0000; tick(3);
        chk("R11 setup pending", 8'(irq_pending), 8'd1);
        cmd_reset_ext = 1'b1;
        cmd_reset_eom = 1'b1;
        tick(1);
        cmd_reset_ext = 1'b0;
        cmd_reset_eom = 1'b0;
        chk("R11 combined pending", 8'(irq_pending), 8'd1);
        chk("R11 combined word", 8'(status_word), 8'b00000);
        pulse_ext();
        chk("R11 final release", 8'(irq_pending), 8'd0);
        chk("R11 final word", 8'(status_word), 8'b10000);

        done = 1'b1;
        finish_run();
    end

endmodule